// File: doc/BRIEF.md
# Packetized Nexus Header Decoder

This block parses the 24-byte header unit that opens every packetized transfer on a parallel storage bus. Header bytes arrive as beats of `LANES` bytes (two by default, a 16-bit word), starting at the beat marked by `in_sof`. While the bytes stream in, the block keeps a private copy of the header. As soon as the beat that carries the CRC interval has been taken, it hands that interval to the neighbouring CRC engine.

The CRC check itself happens outside this block. Once the last of the 24 bytes has been received, the decoder waits for the engine to report on the header's residue. A bad residue raises a one-cycle CRC error flag and the decoded fields stay as they were. A good residue is followed by a check of the type code against the transfer direction, which gives one of two results:

- The header is accepted. `hdr_valid` pulses and the type, tag, LUN, data length and interval fields are updated. A zero data length also raises a logical-disconnect pulse.
- The header is rejected. A one-cycle failure report carries the packetized failure code.

Top module: `iu_hdr_decoder`

## Requirements
- R1: After reset every pulse output (`hdr_valid`, `ldisc`, `crc_err`, `fail_valid`, `ivl_strobe`) is low and every field output, `ivl_value` and `fail_code` are zero.
- R2: A header starts on a beat with `in_valid` and `in_sof` both high. Beat n carries header bytes LANES*n to LANES*n+LANES-1, with the lowest-numbered byte in `in_data[7:0]`. The fields are read from these header bytes, and every multi-byte field is big-endian, so the lowest-numbered byte is its most significant byte:

  | Field | Header bytes |
  |---|---|
  | type | byte 0 |
  | tag | bytes 2 and 3 |
  | LUN | byte 5 |
  | data length | bytes 13 to 15 |
  | CRC interval | bytes 18 and 19 |
- R3: `ivl_strobe` pulses for one cycle in the cycle after the beat holding byte 19 is taken, with `ivl_value` = {byte 18, byte 19}.
- R4: After all 24 bytes are taken, the block waits for `crc_done`. If `crc_ok` is high and the type is legal, `hdr_valid` pulses in the cycle after `crc_done` and the field outputs show the new header in that same cycle.
- R5: If `crc_ok` is low when `crc_done` arrives, `crc_err` pulses in the next cycle. In that case no `hdr_valid` and no `fail_valid` are raised, and the fields keep their old values.
- R6: A type code other than 01h, 02h, 04h, 05h or 08h is reserved. With a good residue it gives `fail_valid` with `fail_code` 06h in the cycle after `crc_done`, and neither `hdr_valid` nor any field change.
- R7: With `dir_i2t`=1 (initiator to target) only the command types 01h and 02h are legal. With `dir_i2t`=0 only 04h, 05h and 08h are legal. A non-reserved type in the wrong direction gives `fail_valid` with code 07h, and the fields do not change.
- R8: An accepted header whose data length is zero raises `ldisc` in the same cycle as `hdr_valid`. A nonzero length leaves `ldisc` low.
- R9: Three kinds of input are ignored:
  - `crc_done` while the block is not waiting;
  - beats without `in_sof` while the block is not collecting;
  - a new `in_sof` in the middle of a header, which discards the partial header and starts again.
- R10: The field outputs hold their values in every cycle without `hdr_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header beat present |
| in_sof | input | 1 | Beat is the first of a header |
| in_data | input | LANES*8 | Header bytes, lowest index in low lane |
| dir_i2t | input | 1 | 1 when the header travels initiator to target |
| crc_done | input | 1 | CRC engine has a verdict on the header |
| crc_ok | input | 1 | Header residue was good |
| ivl_strobe | output | 1 | CRC interval ready for the CRC engine |
| ivl_value | output | 16 | CRC interval in bytes |
| hdr_valid | output | 1 | Header accepted, fields updated |
| iu_type | output | 8 | Type code of the last accepted header |
| iu_tag | output | 16 | Tag |
| iu_lun | output | 8 | Single-level LUN |
| iu_len | output | 24 | Data length |
| ldisc | output | 1 | Accepted header has zero length |
| crc_err | output | 1 | Header residue was bad |
| fail_valid | output | 1 | Header rejected |
| fail_code | output | 8 | Packetized failure code (06h or 07h) |

## Verification
Every result is due a fixed number of cycles after its stimulus:
- `ivl_strobe` and `ivl_value` come one cycle after the beat carrying byte 19.
- `hdr_valid`, `ldisc`, `crc_err`, `fail_valid` and the fields come one cycle after `crc_done`.

The bench drives inputs on the falling edge. Each expected pulse is checked on the falling edge after the rising edge that samples its cause, and again one cycle later, to show that it has dropped. For rejected headers, the fields are checked at the ports against the values of the last accepted header. Ignored stimulus is checked the same way.

// File: rtl/iu_hdr_pkg.sv
package iu_hdr_pkg;
  localparam int HDR_BYTES  = 24;
  localparam int OFS_TYPE   = 0;
  localparam int OFS_TAG_HI = 2;
  localparam int OFS_TAG_LO = 3;
  localparam int OFS_LUN    = 5;
  localparam int OFS_LEN_HI = 13;
  localparam int OFS_LEN_MD = 14;
  localparam int OFS_LEN_LO = 15;
  localparam int OFS_IVL_HI = 18;
  localparam int OFS_IVL_LO = 19;

  typedef enum logic [7:0] {
    K_CMD_LAST  = 8'h01,
    K_CMD_MULTI = 8'h02,
    K_DATA      = 8'h04,
    K_STREAM    = 8'h05,
    K_STATUS    = 8'h08
  } iu_kind_e;

  localparam logic [7:0] FAIL_BAD_TYPE = 8'h06;
  localparam logic [7:0] FAIL_ILLEGAL  = 8'h07;
endpackage

// File: rtl/iu_beat_track.sv
module iu_beat_track
  import iu_hdr_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             crc_done,
  output logic             wr_en,
  output logic [CNT_W-1:0] base,
  output logic             fire,
  output logic             waiting
);
  localparam int LAST_START = HDR_BYTES - LANES;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WAIT} trk_e;
  trk_e             st;
  logic [CNT_W-1:0] cnt;
  logic             last;

  always_comb begin
    wr_en   = in_valid && (in_sof || st == S_FILL);
    base    = in_sof ? '0 : cnt;
    last    = wr_en && (int'(base) >= LAST_START);
    fire    = (st == S_WAIT) && crc_done && !(in_valid && in_sof);
    waiting = (st == S_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else if (wr_en) begin
      if (last) begin
        st  <= S_WAIT;
        cnt <= '0;
      end else begin
        st  <= S_FILL;
        cnt <= base + CNT_W'(LANES);
      end
    end else if (fire) begin
      st <= S_IDLE;
    end
  end

  // R9: a partial header never points past the header end
  a_r9_fill_bound: assert property (@(posedge clk) disable iff (rst)
    (st == S_FILL) |-> (int'(cnt) < HDR_BYTES));

  // R4: the wait state is only entered after an accepted beat
  a_r4_wait_after_beat: assert property (@(posedge clk) disable iff (rst)
    $rose(waiting) |-> $past(in_valid));
endmodule

// File: rtl/iu_byte_store.sv
module iu_byte_store
  import iu_hdr_pkg::*;
#(
  parameter int LANES = 2,
  parameter int CNT_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [CNT_W-1:0]              base,
  input  logic [LANES*8-1:0]            data,
  output logic [HDR_BYTES-1:0][7:0]     shadow,
  output logic                          ivl_strobe,
  output logic [15:0]                   ivl_value
);
  logic [LANES-1:0][7:0]        lane_byte;
  logic [HDR_BYTES-1:0][7:0]    nxt;
  logic                         hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_byte[g] = data[8*g +: 8];
  end

  always_comb begin
    nxt = shadow;
    hit = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (wr_en && ((int'(base) + k) < HDR_BYTES)) begin
        nxt[base + CNT_W'(k)] = lane_byte[k];
        if ((int'(base) + k) == OFS_IVL_LO) hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow     <= '0;
      ivl_strobe <= 1'b0;
      ivl_value  <= '0;
    end else begin
      shadow     <= nxt;
      ivl_strobe <= hit;
      if (hit) ivl_value <= {nxt[OFS_IVL_HI], nxt[OFS_IVL_LO]};
    end
  end

  // R3: the interval strobe always follows an accepted beat
  a_r3_strobe_after_beat: assert property (@(posedge clk) disable iff (rst)
    ivl_strobe |-> $past(wr_en));

  // R3: the interval value only moves together with its strobe
  a_r3_value_hold: assert property (@(posedge clk) disable iff (rst)
    !ivl_strobe |-> $stable(ivl_value));
endmodule

// File: rtl/iu_type_check.sv
module iu_type_check
  import iu_hdr_pkg::*;
(
  input  logic [7:0] kind,
  input  logic       dir_i2t,
  output logic       legal,
  output logic [7:0] code
);
  logic is_cmd, is_tgt;

  always_comb begin
    is_cmd = 1'b0;
    is_tgt = 1'b0;
    case (kind)
      K_CMD_LAST, K_CMD_MULTI:   is_cmd = 1'b1;
      K_DATA, K_STREAM, K_STATUS: is_tgt = 1'b1;
      default: ;
    endcase
    if (!is_cmd && !is_tgt) begin
      legal = 1'b0;
      code  = FAIL_BAD_TYPE;
    end else if (dir_i2t ? is_cmd : is_tgt) begin
      legal = 1'b1;
      code  = 8'h00;
    end else begin
      legal = 1'b0;
      code  = FAIL_ILLEGAL;
    end
  end
endmodule

// File: rtl/iu_hdr_decoder.sv
module iu_hdr_decoder
  import iu_hdr_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sof,
  input  logic [LANES*8-1:0] in_data,
  input  logic               dir_i2t,
  input  logic               crc_done,
  input  logic               crc_ok,
  output logic               ivl_strobe,
  output logic [15:0]        ivl_value,
  output logic               hdr_valid,
  output logic [7:0]         iu_type,
  output logic [15:0]        iu_tag,
  output logic [7:0]         iu_lun,
  output logic [23:0]        iu_len,
  output logic               ldisc,
  output logic               crc_err,
  output logic               fail_valid,
  output logic [7:0]         fail_code
);
  localparam int CNT_W = $clog2(HDR_BYTES + 1);

  logic                      wr_en, fire, waiting;
  logic [CNT_W-1:0]          base;
  logic [HDR_BYTES-1:0][7:0] shadow;
  logic                      legal;
  logic [7:0]                chk_code;
  logic [23:0]               len_new;

  iu_beat_track #(.LANES(LANES), .CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof),
    .crc_done(crc_done), .wr_en(wr_en), .base(base), .fire(fire),
    .waiting(waiting)
  );

  iu_byte_store #(.LANES(LANES), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .base(base), .data(in_data),
    .shadow(shadow), .ivl_strobe(ivl_strobe), .ivl_value(ivl_value)
  );

  iu_type_check u_chk (
    .kind(shadow[OFS_TYPE]), .dir_i2t(dir_i2t), .legal(legal), .code(chk_code)
  );

  assign len_new = {shadow[OFS_LEN_HI], shadow[OFS_LEN_MD], shadow[OFS_LEN_LO]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_valid  <= 1'b0;
      ldisc      <= 1'b0;
      crc_err    <= 1'b0;
      fail_valid <= 1'b0;
      fail_code  <= '0;
      iu_type    <= '0;
      iu_tag     <= '0;
      iu_lun     <= '0;
      iu_len     <= '0;
    end else begin
      hdr_valid  <= 1'b0;
      ldisc      <= 1'b0;
      crc_err    <= 1'b0;
      fail_valid <= 1'b0;
      if (fire) begin
        if (!crc_ok) begin
          crc_err <= 1'b1;
        end else if (!legal) begin
          fail_valid <= 1'b1;
          fail_code  <= chk_code;
        end else begin
          hdr_valid <= 1'b1;
          ldisc     <= (len_new == 24'd0);
          iu_type   <= shadow[OFS_TYPE];
          iu_tag    <= {shadow[OFS_TAG_HI], shadow[OFS_TAG_LO]};
          iu_lun    <= shadow[OFS_LUN];
          iu_len    <= len_new;
        end
      end
    end
  end

  // R4: at most one verdict per header
  a_r4_one_verdict: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hdr_valid, crc_err, fail_valid}));

  // R4: a verdict only follows a CRC report
  a_r4_after_done: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid || crc_err || fail_valid) |-> $past(crc_done));

  // R6 / R7: only the two defined failure codes are reported
  a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
    fail_valid |-> (fail_code == 8'h06 || fail_code == 8'h07));

  // R8: disconnect only with an accepted zero-length header
  a_r8_ldisc_zero: assert property (@(posedge clk) disable iff (rst)
    ldisc |-> (hdr_valid && iu_len == 24'd0));

  // R10: fields hold outside commits
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |-> ($stable(iu_tag) && $stable(iu_len) && $stable(iu_type) && $stable(iu_lun)));
endmodule

// File: tb/sim_iu_hdr_decoder.sv
module sim_iu_hdr_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_sof = 1'b0, dir_i2t = 1'b0;
  logic        crc_done = 1'b0, crc_ok = 1'b0;
  logic [15:0] in_data = '0;
  logic        ivl_strobe, hdr_valid, ldisc, crc_err, fail_valid;
  logic [15:0] ivl_value, iu_tag;
  logic [7:0]  iu_type, iu_lun, fail_code;
  logic [23:0] iu_len;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  logic [7:0]  e_type = '0, e_lun = '0;
  logic [15:0] e_tag = '0;
  logic [23:0] e_len = '0;
  logic [7:0]  hb [24];

  always #5 clk = ~clk;

  iu_hdr_decoder #(.LANES(2)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .dir_i2t(dir_i2t), .crc_done(crc_done), .crc_ok(crc_ok),
    .ivl_strobe(ivl_strobe), .ivl_value(ivl_value), .hdr_valid(hdr_valid),
    .iu_type(iu_type), .iu_tag(iu_tag), .iu_lun(iu_lun), .iu_len(iu_len),
    .ldisc(ldisc), .crc_err(crc_err), .fail_valid(fail_valid), .fail_code(fail_code)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog: act=%0d cycles exp=<20000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_fields(input string req);
    chk(req, "type", 32'(iu_type), 32'(e_type));
    chk(req, "tag",  32'(iu_tag),  32'(e_tag));
    chk(req, "lun",  32'(iu_lun),  32'(e_lun));
    chk(req, "len",  32'(iu_len),  32'(e_len));
  endtask

  task automatic build(input logic [7:0] ty, input logic [15:0] tg, input logic [7:0] ln,
                       input logic [23:0] len, input logic [15:0] ivl);
    for (int i = 0; i < 24; i++) hb[i] = 8'(8'h30 + i);
    hb[0] = ty; hb[2] = tg[15:8]; hb[3] = tg[7:0]; hb[5] = ln;
    hb[13] = len[23:16]; hb[14] = len[15:8]; hb[15] = len[7:0];
    hb[18] = ivl[15:8]; hb[19] = ivl[7:0];
  endtask

  // drives nbeats beats; first beat carries sof when use_sof
  task automatic beats(input int nbeats, input bit use_sof, input logic [15:0] ivl, input bit chk_ivl);
    for (int i = 0; i < nbeats; i++) begin
      @(negedge clk);
      if (chk_ivl && i == 10) begin
        chk("R3", "ivl_strobe", 32'(ivl_strobe), 32'd1);
        chk("R3", "ivl_value", 32'(ivl_value), 32'(ivl));
      end
      if (chk_ivl && i == 9) chk("R3", "ivl_strobe early", 32'(ivl_strobe), 32'd0);
      in_valid = 1'b1;
      in_sof   = use_sof && (i == 0);
      in_data  = {hb[2*i+1], hb[2*i]};
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  // CRC verdict; checks pulses one cycle later and their drop after that
  task automatic verdict(input bit ok, input bit i2t, input string req,
                         input bit e_hv, input bit e_ld, input bit e_ce, input bit e_fv, input logic [7:0] e_code);
    dir_i2t = i2t; crc_done = 1'b1; crc_ok = ok;
    @(negedge clk);
    crc_done = 1'b0; crc_ok = 1'b0;
    chk(req, "hdr_valid",  32'(hdr_valid),  32'(e_hv));
    chk(req, "ldisc",      32'(ldisc),      32'(e_ld));
    chk(req, "crc_err",    32'(crc_err),    32'(e_ce));
    chk(req, "fail_valid", 32'(fail_valid), 32'(e_fv));
    if (e_fv) chk(req, "fail_code", 32'(fail_code), 32'(e_code));
    chk_fields(req);
    @(negedge clk);
    chk(req, "pulses drop", 32'({hdr_valid, ldisc, crc_err, fail_valid}), 32'd0);
  endtask

  task automatic good_hdr(input string req, input logic [7:0] ty, input logic [15:0] tg, input logic [7:0] ln,
                          input logic [23:0] len, input logic [15:0] ivl, input bit i2t);
    build(ty, tg, ln, len, ivl);
    beats(12, 1'b1, ivl, 1'b1);
    e_type = ty; e_tag = tg; e_lun = ln; e_len = len;
    verdict(1'b1, i2t, req, 1'b1, len == 24'd0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic bad_hdr(input string req, input logic [7:0] ty, input bit i2t, input bit ok, input logic [7:0] code);
    build(ty, 16'hDEAD, 8'h99, 24'h000777, 16'h0123);
    beats(12, 1'b1, 16'h0123, 1'b1);
    verdict(ok, i2t, req, 1'b0, 1'b0, !ok, ok, code);
  endtask

  task automatic t_reset;
    chk("R1", "pulses", 32'({hdr_valid, ldisc, crc_err, fail_valid, ivl_strobe}), 32'd0);
    chk("R1", "fail_code", 32'(fail_code), 32'd0);
    chk("R1", "ivl_value", 32'(ivl_value), 32'd0);
    chk_fields("R1");
  endtask

  task automatic t_ignore;
    // R9: crc_done while idle
    crc_done = 1'b1; crc_ok = 1'b1;
    @(negedge clk);
    crc_done = 1'b0;
    chk("R9", "idle done", 32'({hdr_valid, crc_err, fail_valid}), 32'd0);
    // R9: beats without sof while idle, then a verdict
    build(8'h08, 16'h1111, 8'h22, 24'h000000, 16'h0010);
    beats(12, 1'b0, 16'h0, 1'b0);
    chk("R9", "no-sof strobe", 32'(ivl_strobe), 32'd0);
    crc_done = 1'b1; crc_ok = 1'b1; dir_i2t = 1'b0;
    @(negedge clk);
    crc_done = 1'b0;
    chk("R9", "no-sof verdict", 32'({hdr_valid, crc_err, fail_valid}), 32'd0);
    chk_fields("R9");
  endtask

  task automatic t_restart;
    build(8'h08, 16'h7777, 8'h66, 24'h000000, 16'h0001);
    beats(4, 1'b1, 16'h0, 1'b0);
    good_hdr("R9", 8'h05, 16'h4242, 8'h03, 24'h012345, 16'h0200, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    good_hdr("R2", 8'h01, 16'hA5C3, 8'h07, 24'h000200, 16'h0040, 1'b1);
    good_hdr("R4", 8'h02, 16'h0001, 8'hFE, 24'hFEDCBA, 16'hFFFF, 1'b1);
    good_hdr("R8", 8'h04, 16'h1234, 8'h00, 24'h000000, 16'h0000, 1'b0);
    good_hdr("R4", 8'h08, 16'hBEEF, 8'h10, 24'h000012, 16'h0008, 1'b0);
    bad_hdr("R5", 8'h01, 1'b1, 1'b0, 8'h00);
    bad_hdr("R6", 8'h03, 1'b1, 1'b1, 8'h06);
    bad_hdr("R6", 8'hFF, 1'b0, 1'b1, 8'h06);
    bad_hdr("R7", 8'h08, 1'b1, 1'b1, 8'h07);
    bad_hdr("R7", 8'h04, 1'b1, 1'b1, 8'h07);
    bad_hdr("R7", 8'h02, 1'b0, 1'b1, 8'h07);
    t_ignore();
    t_restart();
    repeat (5) @(negedge clk);
    chk_fields("R10");
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule